// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits between an 8-bit host bus and a wider internal register space. The host sees a handful of byte-wide registers at a 3-bit external address. Three of them stage a 22-bit data word. Two more hold a 10-bit internal address and a group chip-select instruction. Touching the lowest staging register launches one access on a simple request/acknowledge memory interface. A host write to it sends the assembled word to the current internal address. A host read of it fetches the word from that address into the staging registers.

Several devices may share one host bus and see the same strobes. Each device compares the chip-select instruction against its own 2-bit ID strap. Only matching devices launch internal accesses or answer reads. This lets the host program a whole group of devices with a single write sequence. Accesses may be chained back to back: each strobe with its own external address is one register access.

Top module: `regbridge`

## Requirements
- R1: After reset, every staging and address register reads as zero, `busy`, `mem_req` and `host_rvalid` are low, and `host_rdata` is zero.
- R2: External addresses 0, 1 and 2 are the low, middle and top bytes of the staged word. The top byte keeps only bits [5:0]: host write bits [7:6] are dropped and read back as zero. Writes to addresses 3, 4 and 5 are ignored, and reads of them return zero.
- R3: Address 7 is the control register: bits [1:0] give internal address bits [9:8], bits [5:2] hold the chip-select instruction, and bits [7:6] read as zero. Address 6 holds internal address bits [7:0]. The two may be written in either order, and both read back their stored values.
- R4: A matching host write to address 0 raises `mem_req` for exactly one cycle, starting the cycle after the strobe. With it, `mem_we`=1, `mem_addr`={ctl[1:0], low}, and `mem_wdata` is the staged word including the byte just written.
- R5: A matching host read of address 0 raises `mem_req` with `mem_we`=0. On the clock edge where the acknowledge is sampled, the returned 22-bit word is loaded into the staging registers. The cycle after that edge, `host_rvalid` pulses with the word's low byte on `host_rdata`.
- R6: After an internal read, reads of addresses 1 and 2 return the middle byte and top 6 bits of the captured word.
- R7: Chip-select instruction decode. 0xxx matches every ID. 1000 matches IDs whose bit 0 is 0, and 1001 matches IDs whose bit 0 is 1. 1100, 1101, 1110 and 1111 match only IDs 00, 01, 10 and 11. 1010 and 1011 match nothing.
- R8: Without a match, host writes still update the staging and address registers but never raise `mem_req`. Host reads leave `host_rvalid` low and `host_rdata` zero.
- R9: `busy` is high from the request until the edge where the acknowledge is sampled. During that time `mem_addr` and `mem_wdata` hold steady, and every host strobe is ignored.
- R10: A matching read of any address other than 0 gives `host_rvalid` and the data one cycle after the strobe. Strobes on consecutive cycles are each taken as a separate access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_id | input | 2 | Local chip ID strap |
| host_sel | input | 1 | Host chip select, active high |
| host_addr | input | 3 | External register address |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, zero when not valid |
| host_rvalid | output | 1 | Read data valid, drives the bus |
| busy | output | 1 | Internal access in flight |
| mem_req | output | 1 | One-cycle internal access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 10 | Internal address |
| mem_wdata | output | 22 | Internal write word |
| mem_rdata | input | 22 | Internal read word |
| mem_ack | input | 1 | One-cycle access acknowledge |

## Verification
Register reads other than address 0 answer one cycle after the strobe. A launching write or read raises `mem_req` and `busy` one cycle after the strobe. Internal read data appears on `host_rdata` one cycle after the edge that samples the acknowledge. The bench drives inputs on the falling edge and samples on the next falling edge. For the address-0 read, it polls `host_rvalid` on falling edges against a cycle limit, because the memory model in the bench chooses the acknowledge latency. Requests are captured by that model at the rising edge where `mem_req` is seen. They are then compared with the address and word the bench computes, after `busy` has dropped.

// File: rtl/regbridge_pkg.sv
// Package: shared address map and chip-select decode for the register bridge.
// Assumes a 3-bit external address and a 4-bit instruction with a 2-bit chip ID.
package regbridge_pkg;
    localparam int          EXT_AW   = 3;
    localparam logic [2:0]  LOW_ADDR = 3'd6;
    localparam logic [2:0]  CTL_ADDR = 3'd7;
    localparam int          CTL_W    = 6;

    // Return 1 when instruction ins selects the chip with identity id.
    function automatic logic chip_hit(input logic [3:0] ins, input logic [1:0] id);
        if (!ins[3])      return 1'b1;
        else if (ins[2])  return id == ins[1:0];
        else if (!ins[1]) return id[0] == ins[0];
        else              return 1'b0;
    endfunction
endpackage

// File: rtl/rb_chip_match.sv
// Module: compares the chip-select instruction with the local ID strap.
// Assumes the instruction is static while an access is decoded.
module rb_chip_match (
    input  logic [3:0] ins,
    input  logic [1:0] id,
    output logic       hit
);
    import regbridge_pkg::*;

    // Decode the group instruction against the local ID.
    always_comb hit = chip_hit(ins, id);

    // Exact-ID instructions never match a different ID (R7).
    always_comb begin
        if (ins[3:2] == 2'b11 && ins[1:0] != id)
            assert_exact_id_R7: assert (!hit);
    end
endmodule

// File: rtl/rb_stage_regs.sv
// Module: host-visible staging data bytes plus control and low address registers.
// Assumes host writes are already qualified (select, strobe, not busy).
module rb_stage_regs #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 22
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 addr,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic                       load_en,
    input  logic [WORD_W-1:0]          load_word,
    output logic [WORD_W-1:0]          word,
    output logic [BYTE_W+1:0]          iaddr,
    output logic [3:0]                 ins,
    output logic [BYTE_W-1:0]          rd_byte
);
    import regbridge_pkg::*;

    localparam int NB    = (WORD_W + BYTE_W - 1) / BYTE_W;
    localparam int TOP_W = WORD_W - (NB - 1) * BYTE_W;

    logic [BYTE_W-1:0] lane_q [NB];
    logic [BYTE_W-1:0] low_q;
    logic [CTL_W-1:0]  ctl_q;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        localparam int LO = g * BYTE_W;
        localparam int W  = (g == NB - 1) ? TOP_W : BYTE_W;
        localparam logic [BYTE_W-1:0] MASK = BYTE_W'((1 << W) - 1);

        // Lane update: internal read load wins over a host write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= '0;
            else if (load_en)
                lane_q[g] <= BYTE_W'(load_word[LO +: W]);
            else if (wr_en && addr == EXT_AW'(g))
                lane_q[g] <= wdata & MASK;
        end

        assign word[LO +: W] = lane_q[g][W-1:0];
    end

    // Address registers: host writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
            ctl_q <= '0;
        end else if (wr_en) begin
            if (addr == LOW_ADDR) low_q <= wdata;
            if (addr == CTL_ADDR) ctl_q <= wdata[CTL_W-1:0];
        end
    end

    assign iaddr = {ctl_q[1:0], low_q};
    assign ins   = ctl_q[5:2];

    // Readback multiplexer for the host data path.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NB; i++)
            if (addr == EXT_AW'(i)) rd_byte = lane_q[i];
        if (addr == LOW_ADDR) rd_byte = low_q;
        if (addr == CTL_ADDR) rd_byte = BYTE_W'(ctl_q);
    end

    // The top lane never holds bits above its width (R2).
    assert_top_lane_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_q[NB-1] >> TOP_W) == '0);
endmodule

// File: rtl/rb_access_seq.sv
// Module: launches one internal access and tracks it until acknowledge.
// Assumes start_wr and start_rd are only raised while idle.
module rb_access_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_rd,
    input  logic mem_ack,
    output logic mem_req,
    output logic mem_we,
    output logic busy,
    output logic rd_load
);
    // Request pulse, direction and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
        end else begin
            mem_req <= 1'b0;
            if (busy) begin
                if (mem_ack) busy <= 1'b0;
            end else if (start_wr || start_rd) begin
                busy    <= 1'b1;
                mem_req <= 1'b1;
                mem_we  <= start_wr;
            end
        end
    end

    // Read completion loads the staging registers.
    assign rd_load = busy && mem_ack && !mem_we;

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_ack |=> busy);
    assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

// File: rtl/regbridge.sv
// Module: top of the indirect register bridge between an 8-bit host and a
// 22-bit internal register space. Assumes one-cycle host strobes and a
// memory side that answers each request with a one-cycle acknowledge.
module regbridge #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          chip_id,
    input  logic                host_sel,
    input  logic [2:0]          host_addr,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [BYTE_W-1:0]   host_rdata,
    output logic                host_rvalid,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [BYTE_W+1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_ack
);
    logic [3:0]        ins;
    logic              hit;
    logic              wr_acc, rd_acc, is_base;
    logic              start_wr, start_rd, rd_load;
    logic [BYTE_W-1:0] rd_byte;

    // Host access qualification; writes win over reads, all blocked while busy.
    always_comb begin
        wr_acc   = host_sel && host_wr && !busy;
        rd_acc   = host_sel && host_rd && !host_wr && !busy;
        is_base  = host_addr == '0;
        start_wr = wr_acc && hit && is_base;
        start_rd = rd_acc && hit && is_base;
    end

    rb_chip_match u_match (.ins(ins), .id(chip_id), .hit(hit));

    rb_stage_regs #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .addr(host_addr),
        .wdata(host_wdata), .load_en(rd_load), .load_word(mem_rdata),
        .word(mem_wdata), .iaddr(mem_addr), .ins(ins), .rd_byte(rd_byte)
    );

    rb_access_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
        .busy(busy), .rd_load(rd_load)
    );

    // Host read response: internal read data or a direct register readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else if (rd_load) begin
            host_rvalid <= 1'b1;
            host_rdata  <= mem_rdata[BYTE_W-1:0];
        end else if (rd_acc && hit && !is_base) begin
            host_rvalid <= 1'b1;
            host_rdata  <= rd_byte;
        end else begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end
    end

    assert_write_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> $past(host_sel && host_wr && host_addr == '0));
    assert_stable_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_ack |=> $stable(mem_addr) && $stable(mem_wdata));
    assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rvalid |-> host_rdata == '0);
endmodule

// File: tb/regbridge_tb.sv
module regbridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  chip_id = 2'b00;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rvalid, busy, mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [21:0] mem_wdata, mem_rdata;
    logic        mem_ack;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    regbridge u_dut (.*);

    // Memory model with bench-chosen acknowledge latency.
    logic [21:0] mem [1024];
    logic [21:0] exp_mem [1024];
    int          lat = 1;
    logic        pend = 1'b0, ack_q = 1'b0;
    int          cnt = 0, nreq = 0;
    logic [9:0]  cap_addr = '0;
    logic        cap_we = 1'b0;
    logic [21:0] cap_data = '0;

    assign mem_ack   = ack_q;
    assign mem_rdata = mem[cap_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; ack_q <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (mem_req) begin
                pend <= 1'b1; cnt <= lat; nreq <= nreq + 1;
                cap_addr <= mem_addr; cap_we <= mem_we; cap_data <= mem_wdata;
            end else if (pend) begin
                if (cnt == 0) begin
                    ack_q <= 1'b1; pend <= 1'b0;
                    if (cap_we) mem[cap_addr] <= cap_data;
                end else cnt <= cnt - 1;
            end
        end
    end

    function automatic bit exp_hit(input logic [3:0] ins, input logic [1:0] id);
        case (ins)
            4'b1000: return id[0] == 1'b0;
            4'b1001: return id[0] == 1'b1;
            4'b1010, 4'b1011: return 1'b0;
            4'b1100: return id == 2'b00;
            4'b1101: return id == 2'b01;
            4'b1110: return id == 2'b10;
            4'b1111: return id == 2'b11;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic v, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rvalid; d = host_rdata;
    endtask

    task automatic read_base(output logic v, output logic [7:0] d);
        host_read(3'd0, v, d);
        for (int i = 0; i < 20 && !host_rvalid; i++) @(negedge clk);
        v = host_rvalid; d = host_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 30 && busy; i++) @(negedge clk);
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] e);
        logic v; logic [7:0] d;
        host_read(a, v, d);
        check({tag, " valid"}, 32'(v), 32'd1);
        check(tag, 32'(d), 32'(e));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic v; logic [7:0] d;
        logic [21:0] w; logic [9:0] a; logic [3:0] ins; logic [1:0] id;
        int n0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 rvalid", 32'(host_rvalid), 0);
        check("R1 rdata", 32'(host_rdata), 0);
        expect_reg("R1 ctl", 3'd7, 8'h00);
        expect_reg("R1 low", 3'd6, 8'h00);
        expect_reg("R1 byte1", 3'd1, 8'h00);
        expect_reg("R1 byte2", 3'd2, 8'h00);

        // R2 top-byte masking and unused addresses
        host_write(3'd2, 8'hFF);
        expect_reg("R2 top byte mask", 3'd2, 8'h3F);
        host_write(3'd4, 8'h5A);
        expect_reg("R2 unused addr", 3'd4, 8'h00);

        // R3 address registers in reverse order, bits [7:6] dropped
        host_write(3'd6, 8'hA5);
        host_write(3'd7, 8'hC2);
        expect_reg("R3 ctl readback", 3'd7, 8'h02);
        expect_reg("R3 low readback", 3'd6, 8'hA5);

        // R10 chained writes on consecutive cycles, then R4 request contents
        n0 = nreq;
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = 3'd2; host_wdata = 8'h15;
        @(negedge clk); host_addr = 3'd1; host_wdata = 8'h9C;
        @(negedge clk); host_addr = 3'd0; host_wdata = 8'h3E;
        @(negedge clk); host_wr = 1'b0;
        check("R4 req pulse", 32'(mem_req), 1);
        check("R4 we", 32'(mem_we), 1);
        check("R9 busy after launch", 32'(busy), 1);
        wait_idle();
        check("R10 chained count", 32'(nreq - n0), 1);
        check("R4 addr", 32'(cap_addr), 32'h2A5);
        check("R10 chained word", 32'(cap_data), 32'h159C3E);
        exp_mem[10'h2A5] = 22'h159C3E;

        // R9 host strobes ignored while busy
        lat = 6;
        host_write(3'd0, 8'h11);
        host_write(3'd6, 8'h77);
        check("R9 still busy", 32'(busy), 1);
        wait_idle();
        exp_mem[10'h2A5] = 22'h159C11;
        expect_reg("R9 ignored write", 3'd6, 8'hA5);
        lat = 1;

        // R8 non-matching reads stay off the bus, R7 exact-ID decode
        chip_id = 2'b01;
        host_write(3'd7, 8'h30);          // instruction 1100
        host_read(3'd6, v, d);
        check("R8 no rvalid", 32'(v), 0);
        check("R8 quiet data", 32'(d), 0);
        n0 = nreq;
        host_write(3'd0, 8'h44);
        repeat (4) @(negedge clk);
        check("R8 no request", 32'(nreq - n0), 0);

        // Random mix: decode, write launch, readback through internal read
        for (int it = 0; it < 80; it++) begin
            lat = $urandom_range(0, 3);
            id = 2'($urandom); ins = 4'($urandom); a = 10'($urandom); w = 22'($urandom);
            chip_id = id;
            host_write(3'd7, {2'($urandom), ins, a[9:8]});
            host_write(3'd6, a[7:0]);
            host_write(3'd2, {2'($urandom), w[21:16]});
            host_write(3'd1, w[15:8]);
            n0 = nreq;
            host_write(3'd0, w[7:0]);
            wait_idle();
            repeat (3) @(negedge clk);
            if (exp_hit(ins, id)) begin
                check("R7 hit request", 32'(nreq - n0), 1);
                check("R4 rnd addr", 32'(cap_addr), 32'(a));
                check("R4 rnd word", 32'(cap_data), 32'(w));
                exp_mem[a] = w;
            end else begin
                check("R8 miss no request", 32'(nreq - n0), 0);
            end
            // staging kept the word either way (R8)
            host_write(3'd7, {4'b0000, a[9:8]});
            expect_reg("R8 staging kept", 3'd2, {2'b00, w[21:16]});
            expect_reg("R3 ctl rnd", 3'd7, {6'b0, a[9:8]});
            read_base(v, d);
            check("R5 read valid", 32'(v), 1);
            check("R5 low byte", 32'(d), 32'(exp_mem[a][7:0]));
            expect_reg("R6 mid byte", 3'd1, exp_mem[a][15:8]);
            expect_reg("R6 top byte", 3'd2, {2'b00, exp_mem[a][21:16]});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule